// File: doc/BRIEF.md
# Burst Pseudo-SRAM Bus Emulator

This block is a synchronous slave that behaves, at its pins, like the burst-mode side of a 16-bit mobile pseudo-SRAM. It keeps its words in a small internal array. A host selects it with two chip enables and pulses an address strobe to load a start address. It then moves through consecutive words on every valid clock edge. Words are read out when output enable is low and written when the burst was opened with write enable low.

While a burst is open, the host can pause and continue it through the enable strobes. The two byte lanes mask each word independently. Opening a write burst with both lanes disabled aborts it. Two static configuration inputs set the rest of the behaviour. One picks the clock edge that counts. The other picks whether write enable acts as a level that pauses a write burst, or is ignored once the burst has started. Any illegal input pattern sets a sticky error flag and leaves the array untouched.

Top module: `bpsram_emul`

## Requirements
- R1: While `cen_a_n` is high or `cen_b` is low, `dq_oe_lo`, `dq_oe_hi` and `stall_oe` are all 0, whatever the other inputs are.
- R2: A valid edge loads `addr_in` as the burst address when the block is idle, selected (`cen_a_n`=0, `cen_b`=1), `addr_strobe_n` is 0 and the recovery window of R11 has elapsed. The burst is a write burst if `we_n` is 0 at that edge, otherwise a read burst. `stall_oe` becomes 1 after the edge, and in a read burst `stall_out` stays 1 until the first word is out.
- R3: With `cfg_fall_edge`=0 only rising clock edges act; with `cfg_fall_edge`=1 only falling edges act.
- R4: In a read burst, a valid edge with `addr_strobe_n`=1 and `oe_n`=0 puts the word at the current address on `dq_out` after that edge and advances the address by one. While that word is shown, `stall_out` is 0.
- R5: In a read burst, `oe_n`=1 pauses the burst. The data lanes are undriven, `stall_out` is 1, the address holds, and taking `oe_n` low again continues with the next word.
- R6: In a write burst, each advancing valid edge stores `dq_in` into the enabled byte lanes at the current address and advances the address. With `cfg_we_level`=1, `we_n`=1 pauses the burst: no store, no advance, `stall_out`=1. With `cfg_we_level`=0, `we_n` has no effect after the burst is opened.
- R7: The burst address wraps from DEPTH-1 to 0.
- R8: Lane enables are active low: `lane_lo_n` covers `dq[7:0]` and `lane_hi_n` covers `dq[15:8]`. A lane is driven only in a read burst after its first word, with `oe_n`=0, `we_n`=1 and that lane's enable low. A write stores only into lanes whose enable is low.
- R9: A write burst opened with both lane enables high ends on its first advancing edge. Nothing is stored and `stall_oe` returns to 0.
- R10: Deselecting the block at a valid edge ends any burst. Selecting it again without a new address load causes no access.
- R11: After an address load, a new load is accepted only once the block has seen REC_EDGES valid edges while deselected. An earlier strobe is ignored.
- R12: `oe_n` and `we_n` both low while selected, or lane enables that differ from those loaded at burst start, set `err_flag`. That edge neither stores nor advances. Only reset clears the flag.
- R13: After a synchronous active-low reset the block is idle, nothing is driven and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the valid edge |
| cfg_fall_edge | input | 1 | 1: falling edge is the valid edge; 0: rising edge |
| cfg_we_level | input | 1 | 1: write enable level pauses a write burst |
| cen_a_n | input | 1 | Primary chip enable, active low |
| cen_b | input | 1 | Secondary chip enable, active high |
| addr_strobe_n | input | 1 | Low: load start address; high: advance |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lane_lo_n | input | 1 | Low byte lane enable, active low |
| lane_hi_n | input | 1 | High byte lane enable, active low |
| addr_in | input | AW | Start word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe_lo | output | 1 | Drive enable for dq_out[7:0] |
| dq_oe_hi | output | 1 | Drive enable for dq_out[15:8] |
| stall_out | output | 1 | 1: no valid data or burst paused |
| stall_oe | output | 1 | Drive enable for stall_out |
| err_flag | output | 1 | Sticky illegal-input flag |

## Verification
The bench builds the block with DEPTH=16 and REC_EDGES=3. The small array lets a four-word burst cross the wrap point and lets one full burst fill every word, so later read-backs are fully defined. A recovery window of three edges separates a premature strobe after one deselected edge from an accepted one. Both configuration corners are built in turn through reset: rising edge with edge-style writes, and falling edge with level-style writes.

// File: rtl/bpsram_pkg.sv
// Shared types for the burst pseudo-SRAM emulator.
// Assumes a 16-bit word split into two 8-bit lanes.
package bpsram_pkg;
    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int NLANE  = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bst_t;
endpackage

// File: rtl/bpsram_array.sv
// Word array split into independent byte-lane memories.
// Registered read, lane-masked write. Assumes the controller never
// requests a read and a write on the same edge.
module bpsram_array
    import bpsram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NLANE-1:0]  wr_lane,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        // store one lane of write data when its enable is set
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // capture the addressed byte on a read step
        always_ff @(posedge clk) begin
            if (rd_en) begin
                lane_q <= lane_mem[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R6
endmodule

// File: rtl/bpsram_ctrl.sv
// Burst controller: address load, stepping, pause, abort, recovery
// window and sticky error detection. Runs on the selected valid edge.
// Assumes DEPTH is a power of two so the address counter wraps freely.
module bpsram_ctrl
    import bpsram_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int REC_EDGES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int RW = $clog2(REC_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_level,
    input  logic             cen_a_n,
    input  logic             cen_b,
    input  logic             addr_strobe_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [NLANE-1:0] lanes_n,
    input  logic [AW-1:0]    addr_in,
    output logic             sel,
    output logic             busy,
    output logic             rd_active,
    output logic             dvalid,
    output logic             rd_en,
    output logic             wr_en,
    output logic [NLANE-1:0] wr_lane,
    output logic [AW-1:0]    mem_addr,
    output logic             err
);
    bst_t             state;
    logic [AW-1:0]    ptr;
    logic [NLANE-1:0] lanes_q;
    logic [RW-1:0]    rec_cnt;
    logic             clash, lane_bad, rec_ok, do_latch, wr_go, abort, err_set;

    // decode this edge's action from the pins and burst state
    always_comb begin
        sel      = !cen_a_n && cen_b;
        clash    = !oe_n && !we_n;
        lane_bad = (lanes_n != lanes_q);
        rec_ok   = (rec_cnt == RW'(REC_EDGES));
        do_latch = sel && !clash && !addr_strobe_n && (state == BST_IDLE) && rec_ok;
        rd_en    = sel && !clash && addr_strobe_n && (state == BST_READ)
                   && !lane_bad && !oe_n;
        wr_go    = sel && !clash && addr_strobe_n && (state == BST_WRITE)
                   && !lane_bad && (!cfg_we_level || !we_n);
        abort    = wr_go && (lanes_q == '1);
        wr_en    = wr_go && !abort;
        err_set  = sel && (clash || ((state != BST_IDLE) && addr_strobe_n && lane_bad));
    end

    assign busy      = (state != BST_IDLE);
    assign rd_active = (state == BST_READ);
    assign wr_lane   = ~lanes_q;
    assign mem_addr  = ptr;

    // burst state, address counter, recovery count and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BST_IDLE;
            ptr     <= '0;
            lanes_q <= '1;
            dvalid  <= 1'b0;
            err     <= 1'b0;
            rec_cnt <= RW'(REC_EDGES);
        end else begin
            if (err_set) begin
                err <= 1'b1;
            end
            if (!sel) begin
                state  <= BST_IDLE;
                dvalid <= 1'b0;
                if (!rec_ok) begin
                    rec_cnt <= rec_cnt + 1'b1;
                end
            end else if (do_latch) begin
                state   <= we_n ? BST_READ : BST_WRITE;
                ptr     <= addr_in;
                lanes_q <= lanes_n;
                dvalid  <= 1'b0;
                rec_cnt <= '0;
            end else if (rd_en || wr_en) begin
                ptr    <= ptr + 1'b1;
                dvalid <= 1'b1;
            end else if (abort) begin
                state  <= BST_IDLE;
                dvalid <= 1'b0;
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R12
    AST_CLASH_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && busy && !oe_n && !we_n) |=> $stable(ptr)); // R12
    AST_PAUSE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_active && addr_strobe_n && oe_n) |=> $stable(ptr)); // R5
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |=> (ptr == $past(ptr) + 1'b1)); // R4
    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !busy); // R10
    AST_NO_LANE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && busy && !rd_active && addr_strobe_n && !clash && lanes_n == '1
         && lanes_q == '1 && (!cfg_we_level || !we_n)) |=> !busy); // R9
endmodule

// File: rtl/bpsram_pads.sv
// Output-side decode: per-lane drive enables and the stall pin.
// Purely combinational; assumes dvalid marks that rdata holds a burst word.
module bpsram_pads
    import bpsram_pkg::*;
(
    input  logic              sel,
    input  logic              busy,
    input  logic              rd_active,
    input  logic              dvalid,
    input  logic              cfg_we_level,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [NLANE-1:0]  lanes_n,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] dq_out,
    output logic [NLANE-1:0]  dq_oe,
    output logic              stall_out,
    output logic              stall_oe
);
    logic show;

    // drive lanes and stall only inside a selected burst
    always_comb begin
        show     = sel && rd_active && dvalid && !oe_n && we_n;
        dq_oe    = show ? ~lanes_n : '0;
        dq_out   = rdata;
        stall_oe = sel && busy;
        if (!stall_oe) begin
            stall_out = 1'b0;
        end else if (rd_active) begin
            stall_out = oe_n || !dvalid;
        end else begin
            stall_out = cfg_we_level && we_n;
        end
    end
endmodule

// File: rtl/bpsram_emul.sv
// Top of the burst pseudo-SRAM emulator. Picks the valid clock edge,
// then joins controller, array and output decode.
// Assumes cfg_fall_edge changes only while rst_n is held low.
module bpsram_emul
    import bpsram_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int REC_EDGES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fall_edge,
    input  logic              cfg_we_level,
    input  logic              cen_a_n,
    input  logic              cen_b,
    input  logic              addr_strobe_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic [AW-1:0]     addr_in,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi,
    output logic              stall_out,
    output logic              stall_oe,
    output logic              err_flag
);
    logic             vclk;
    logic [NLANE-1:0] lanes_n, wr_lane, dq_oe;
    logic             sel, busy, rd_active, dvalid, rd_en, wr_en;
    logic [AW-1:0]    mem_addr;
    logic [WORD_W-1:0] rdata;

    // valid edge becomes the rising edge of vclk
    assign vclk    = clk ^ cfg_fall_edge;
    assign lanes_n = {lane_hi_n, lane_lo_n};

    bpsram_ctrl #(.DEPTH(DEPTH), .REC_EDGES(REC_EDGES)) u_ctrl (
        .clk(vclk), .rst_n(rst_n), .cfg_we_level(cfg_we_level),
        .cen_a_n(cen_a_n), .cen_b(cen_b), .addr_strobe_n(addr_strobe_n),
        .oe_n(oe_n), .we_n(we_n), .lanes_n(lanes_n), .addr_in(addr_in),
        .sel(sel), .busy(busy), .rd_active(rd_active), .dvalid(dvalid),
        .rd_en(rd_en), .wr_en(wr_en), .wr_lane(wr_lane),
        .mem_addr(mem_addr), .err(err_flag)
    );

    bpsram_array #(.DEPTH(DEPTH)) u_array (
        .clk(vclk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_lane(wr_lane), .addr(mem_addr), .wdata(dq_in), .rdata(rdata)
    );

    bpsram_pads u_pads (
        .sel(sel), .busy(busy), .rd_active(rd_active), .dvalid(dvalid),
        .cfg_we_level(cfg_we_level), .oe_n(oe_n), .we_n(we_n),
        .lanes_n(lanes_n), .rdata(rdata), .dq_out(dq_out), .dq_oe(dq_oe),
        .stall_out(stall_out), .stall_oe(stall_oe)
    );

    assign dq_oe_lo = dq_oe[0];
    assign dq_oe_hi = dq_oe[1];
endmodule

// File: tb/sim_bpsram_emul.sv
// Scoreboard bench: drivers queue expected read words, a monitor
// pops them on the edge they are due and compares the pins.
module sim_bpsram_emul;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 16;
    localparam int REC    = 3;
    localparam int AW     = 4;

    typedef struct packed {
        int          cyc;
        logic [15:0] d;
        logic [1:0]  m;
    } exp_t;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic rst_n, fall, we_lvl, cen_a_n, cen_b, strobe_n, oe_n, we_n, lo_n, hi_n;
    logic [AW-1:0] addr_in;
    logic [15:0] dq_in, dq_out;
    logic dq_oe_lo, dq_oe_hi, stall_out, stall_oe, err_flag;

    exp_t exp_q[$];
    logic [15:0] model [DEPTH];
    int total = 0, bad = 0, ecount = 0, p = 0;
    logic [1:0] cur_m;
    bit done = 0;

    bpsram_emul #(.DEPTH(DEPTH), .REC_EDGES(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fall_edge(fall), .cfg_we_level(we_lvl),
        .cen_a_n(cen_a_n), .cen_b(cen_b), .addr_strobe_n(strobe_n),
        .oe_n(oe_n), .we_n(we_n), .lane_lo_n(lo_n), .lane_hi_n(hi_n),
        .addr_in(addr_in), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .stall_out(stall_out),
        .stall_oe(stall_oe), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_edge();
        if (fall) @(negedge clk);
        else      @(posedge clk);
    endtask

    task automatic edge_go();
        wait_edge();
        #2;
    endtask

    // monitor: compare queued read words one time unit after their edge
    initial begin
        exp_t e;
        forever begin
            wait_edge();
            ecount++;
            #1;
            while (exp_q.size() > 0 && exp_q[0].cyc < ecount) begin
                e = exp_q.pop_front();
                total++; bad++;
                $display("FAIL R4 word missed actual=none expected=%0h", e.d);
            end
            if (exp_q.size() > 0 && exp_q[0].cyc == ecount) begin
                e = exp_q.pop_front();
                chk("R4 R8 lo drive", 32'(dq_oe_lo), 32'(e.m[0]));
                chk("R4 R8 hi drive", 32'(dq_oe_hi), 32'(e.m[1]));
                chk("R4 stall low", 32'(stall_out), 32'd0);
                chk("R4 data", 32'(dq_out & {{8{e.m[1]}}, {8{e.m[0]}}}),
                    32'(e.d & {{8{e.m[1]}}, {8{e.m[0]}}}));
            end
        end
    end

    task automatic bus_idle();
        cen_a_n = 1; cen_b = 1; strobe_n = 1; oe_n = 1; we_n = 1;
        lo_n = 1; hi_n = 1; dq_in = '0; addr_in = '0;
    endtask

    task automatic do_reset(input logic f, input logic wl);
        rst_n = 0; fall = f; we_lvl = wl;
        bus_idle();
        repeat (3) edge_go();
        rst_n = 1;
    endtask

    task automatic deselect(input int n);
        bus_idle();
        repeat (n) edge_go();
    endtask

    task automatic latch(input logic [AW-1:0] a, input bit wr, input logic [1:0] lanes);
        cen_a_n = 0; cen_b = 1; strobe_n = 0; oe_n = 1; we_n = wr ? 1'b0 : 1'b1;
        {hi_n, lo_n} = lanes; addr_in = a; p = a; cur_m = ~lanes;
        edge_go();
    endtask

    task automatic rd_step();
        strobe_n = 1; oe_n = 0; we_n = 1;
        exp_q.push_back('{ecount + 1, model[p], cur_m});
        p = (p + 1) % DEPTH;
        edge_go();
    endtask

    task automatic wr_step(input logic [15:0] d);
        strobe_n = 1; oe_n = 1; we_n = we_lvl ? 1'b0 : 1'b1; dq_in = d;
        if (cur_m[0]) model[p][7:0]  = d[7:0];
        if (cur_m[1]) model[p][15:8] = d[15:8];
        p = (p + 1) % DEPTH;
        edge_go();
    endtask

    task automatic rd_burst(input logic [AW-1:0] a, input int n, input logic [1:0] lanes);
        latch(a, 0, lanes);
        repeat (n) rd_step();
        deselect(REC);
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input int n, input logic [15:0] base,
                            input logic [1:0] lanes);
        latch(a, 1, lanes);
        for (int i = 0; i < n; i++) wr_step(base + 16'(i) * 16'h0111);
        deselect(REC);
    endtask

    initial begin
        do_reset(0, 0);
        // R13 reset state
        chk("R13 lo drive", 32'(dq_oe_lo), 0);
        chk("R13 hi drive", 32'(dq_oe_hi), 0);
        chk("R13 stall drive", 32'(stall_oe), 0);
        chk("R13 err", 32'(err_flag), 0);

        // R6 fill array, write enable ignored inside burst (edge style)
        wr_burst(0, DEPTH, 16'hC3A0, 2'b00);
        // R4 plain read burst
        rd_burst(3, 5, 2'b00);

        // R5 pause and continue
        latch(10, 0, 2'b00);
        chk("R2 stall before first word", 32'(stall_out), 1);
        rd_step(); rd_step();
        strobe_n = 1; oe_n = 1; we_n = 1;
        edge_go();
        chk("R5 paused stall", 32'(stall_out), 1);
        chk("R5 paused stall driven", 32'(stall_oe), 1);
        chk("R5 paused lanes", 32'({dq_oe_hi, dq_oe_lo}), 0);
        edge_go();
        rd_step(); rd_step();
        deselect(REC);

        // R7 wrap across the top of the array
        wr_burst(14, 4, 16'h5E10, 2'b00);
        rd_burst(14, 4, 2'b00);

        // R8 byte masking: store low lane only, read each lane alone
        wr_burst(5, 1, 16'h9A7B, 2'b10);
        rd_burst(5, 1, 2'b00);
        rd_burst(5, 1, 2'b01);
        rd_burst(5, 1, 2'b10);

        // R9 abort with both lanes disabled
        latch(2, 1, 2'b11);
        strobe_n = 1; oe_n = 1; we_n = 1; dq_in = 16'hFFFF;
        edge_go();
        chk("R9 burst ended", 32'(stall_oe), 0);
        deselect(REC);
        rd_burst(2, 1, 2'b00);

        // R11 early strobe after one deselected edge is ignored
        latch(2, 0, 2'b00);
        rd_step();
        deselect(1);
        latch(5, 0, 2'b00);
        chk("R11 early load ignored", 32'(stall_oe), 0);
        deselect(REC);
        latch(5, 0, 2'b00);
        chk("R2 R11 load accepted", 32'(stall_oe), 1);
        rd_step();
        deselect(REC);

        // R1 R10 standby mid-burst
        latch(6, 0, 2'b00);
        rd_step();
        cen_a_n = 1; #1;
        chk("R1 primary high", 32'({dq_oe_hi, dq_oe_lo, stall_oe}), 0);
        cen_a_n = 0; cen_b = 0; #1;
        chk("R1 secondary low", 32'({dq_oe_hi, dq_oe_lo, stall_oe}), 0);
        cen_b = 1; cen_a_n = 1;
        edge_go();
        cen_a_n = 0; strobe_n = 1; oe_n = 0; we_n = 1;
        edge_go();
        chk("R10 no access after reselect", 32'({dq_oe_hi, dq_oe_lo, stall_oe}), 0);
        deselect(REC);

        // R12 lane change mid-write: flagged, not stored
        latch(8, 1, 2'b00);
        wr_step(16'h1234);
        strobe_n = 1; oe_n = 1; we_n = 1; lo_n = 1; dq_in = 16'hBEEF;
        edge_go();
        chk("R12 lane change flag", 32'(err_flag), 1);
        deselect(REC);
        rd_burst(8, 2, 2'b00);
        do_reset(0, 0);
        chk("R12 R13 reset clears flag", 32'(err_flag), 0);

        // R12 clash in read burst: flagged, address holds, lanes quiet
        latch(3, 0, 2'b00);
        rd_step();
        strobe_n = 1; oe_n = 0; we_n = 0;
        edge_go();
        chk("R12 clash flag", 32'(err_flag), 1);
        chk("R8 write enable mutes lanes", 32'({dq_oe_hi, dq_oe_lo}), 0);
        rd_step();
        deselect(REC);

        // R3 falling edge and level-style writes
        do_reset(1, 1);
        chk("R13 reset fall mode", 32'({err_flag, stall_oe}), 0);
        latch(0, 0, 2'b00);
        strobe_n = 1; oe_n = 0; we_n = 1;
        @(posedge clk); #1;
        chk("R3 rising edge inert", 32'({stall_out, dq_oe_lo}), 32'b10);
        @(negedge clk); #1;
        chk("R3 falling edge acts", 32'(dq_oe_lo), 1);
        chk("R3 falling data", 32'(dq_out), 32'(model[0]));
        #1;
        deselect(REC);

        // R6 write pause by write enable level
        latch(4, 1, 2'b00);
        wr_step(16'h7E01);
        strobe_n = 1; oe_n = 1; we_n = 1;
        edge_go();
        chk("R6 write paused stall", 32'(stall_out), 1);
        wr_step(16'h7E02);
        deselect(REC);
        rd_burst(4, 3, 2'b00);

        deselect(2);
        chk("R4 all words seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule